// File: doc/BRIEF.md
# Video Sync Conditioner with Field Classification

This block sits at the input of a parallel video capture path running on the incoming pixel clock. It takes the raw horizontal and vertical sync lines of a BT.601-style source and flips each one if a static polarity bit asks for it. The vertical sync can be sampled on either clock edge. Both syncs are re-timed into the rising-edge domain and driven out as active-high levels.

Every active-going edge of the conditioned vertical sync is classified as the start of a top field or a bottom field. The rule is how close the edge lies to a horizontal sync edge. If a horizontal edge falls within a programmable number of cycles before or after the vertical edge, or in the same cycle, the field is top. Otherwise it is bottom. The decision can wait for a horizontal edge that comes later, but never for more than skew+1 cycles. When the decision is made, the field flag is updated and a one-cycle strobe marks the new field.

Top module: `sync_field_detect`

## Requirements
- R1: `hs_out` equals `hs_in` XOR `hs_invert`, delayed by two rising clock edges. With the input held at its idle level (`hs_invert`), `hs_out` is 0.
- R2: When `vs_fall_sample` is 0, `vs_out` equals `vs_in` XOR `vs_invert`, delayed by two rising clock edges.
- R3: When `vs_fall_sample` is 1, `vs_in` is captured on the falling clock edge and then re-registered on the rising edge. `vs_out` and every field decision therefore come exactly one cycle earlier than with rising-edge sampling.
- R4: A sync event is a 0-to-1 change of the conditioned signal.
- R5: If a horizontal event happens in the same cycle as a vertical event, or 1 to `skew` cycles before it, the vertical event is classified as top. `field_start` pulses in the cycle after the vertical event, with `field_top`=1.
- R6: If the first later horizontal event comes k cycles after an unclassified vertical event, with 1 <= k <= `skew`, the field is top. `field_start` pulses in the cycle after that horizontal event.
- R7: Otherwise the field is bottom. `field_start` pulses `skew`+1 cycles after the vertical event, with `field_top`=0.
- R8: With `skew`=0, only an exact same-cycle coincidence gives top. Any other vertical event is bottom, with its strobe in the next cycle.
- R9: Each vertical event produces exactly one single-cycle `field_start`. `field_top` changes only in a cycle where `field_start` is high.
- R10: After reset, `field_top` and `field_start` are 0. No event is produced until a conditioned sync has been seen low and then high, whatever the polarity bits are.
- R11: The count of cycles since the last horizontal event saturates rather than wrapping. With `skew`=1023, distances of 1023 give top and distances of 1024 give bottom, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| hs_invert | input | 1 | 1 inverts horizontal sync |
| vs_invert | input | 1 | 1 inverts vertical sync |
| vs_fall_sample | input | 1 | 0 samples vertical sync on the rising edge, 1 on the falling edge |
| skew | input | SKEW_W | Coincidence window in clock cycles |
| hs_out | output | 1 | Conditioned horizontal sync, active high |
| vs_out | output | 1 | Conditioned vertical sync, active high |
| field_top | output | 1 | 1 for top field, 0 for bottom field |
| field_start | output | 1 | One-cycle strobe when a field decision is issued |

## Verification
The bench sweeps the signed offset between a horizontal pulse and a vertical pulse over the whole window plus two cycles on each side. It does this for several small skew values, both sampling edges and all four polarity combinations.
- Offsets at exactly ±skew and at ±(skew+1) separate an off-by-one in the lookback comparison from one in the lookahead comparison.
- The sign of the offset separates an immediate decision from a deferred one, through the strobe cycle.
- Repeating each offset with falling-edge sampling shows the one-cycle advance.
- A few trials at the largest skew, 1023, at distances of 1023 and 1024, check that the counter saturates and that the window does not wrap.

// File: rtl/sync_field_detect.sv
module sync_field_detect #(
  parameter int SKEW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              hs_invert,
  input  logic              vs_invert,
  input  logic              vs_fall_sample,
  input  logic [SKEW_W-1:0] skew,
  output logic              hs_out,
  output logic              vs_out,
  output logic              field_top,
  output logic              field_start
);
  localparam int CW = SKEW_W + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic hs_r1, hs_s, vs_r1, vs_n, vs_s;
  logic hs_d, vs_d;
  logic [CW-1:0] cnt;
  logic pend, pend_nx;
  logic [SKEW_W-1:0] win, win_nx;
  logic issue, top_nx;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) vs_n <= 1'b0;
    else        vs_n <= vs_in;

  assign hs_out = hs_s ^ hs_invert;
  assign vs_out = vs_s ^ vs_invert;

  wire hs_edge  = hs_out & ~hs_d;
  wire vs_edge  = vs_out & ~vs_d;
  wire lookback = hs_edge || (cnt <= {1'b0, skew});

  always_comb begin
    issue   = 1'b0;
    top_nx  = 1'b0;
    pend_nx = pend;
    win_nx  = win;
    if (vs_edge) begin
      if (lookback || skew == '0) begin
        issue   = 1'b1;
        top_nx  = lookback;
        pend_nx = 1'b0;
      end else begin
        pend_nx = 1'b1;
        win_nx  = SKEW_W'(1);
      end
    end else if (pend) begin
      if (hs_edge) begin
        issue   = 1'b1;
        top_nx  = 1'b1;
        pend_nx = 1'b0;
      end else if (win == skew) begin
        issue   = 1'b1;
        pend_nx = 1'b0;
      end else begin
        win_nx  = win + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_r1       <= 1'b0;
      hs_s        <= 1'b0;
      vs_r1       <= 1'b0;
      vs_s        <= 1'b0;
      hs_d        <= 1'b1;
      vs_d        <= 1'b1;
      cnt         <= CMAX;
      pend        <= 1'b0;
      win         <= '0;
      field_top   <= 1'b0;
      field_start <= 1'b0;
    end else begin
      hs_r1       <= hs_in;
      hs_s        <= hs_r1;
      vs_r1       <= vs_in;
      vs_s        <= vs_fall_sample ? vs_n : vs_r1;
      hs_d        <= hs_out;
      vs_d        <= vs_out;
      if (hs_edge)           cnt <= CW'(1);
      else if (cnt != CMAX)  cnt <= cnt + 1'b1;
      pend        <= pend_nx;
      win         <= win_nx;
      field_start <= issue;
      if (issue) field_top <= top_nx;
    end
  end
endmodule

module sync_field_detect_chk #(
  parameter int SKEW_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_in,
  input logic              vs_in,
  input logic              hs_invert,
  input logic              vs_invert,
  input logic              vs_fall_sample,
  input logic [SKEW_W-1:0] skew,
  input logic              hs_out,
  input logic              vs_out,
  input logic              field_top,
  input logic              field_start,
  input logic              hs_edge,
  input logic              vs_edge,
  input logic [SKEW_W:0]   cnt
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        age <= '0;
    else if (age != 3) age <= age + 1'b1;

  p_hs_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2) |-> (hs_out == ($past(hs_in, 2) ^ hs_invert)));

  p_vs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2 && !vs_fall_sample) |-> (vs_out == ($past(vs_in, 2) ^ vs_invert)));

  p_coincide_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_edge && hs_edge) |=> (field_start && field_top));

  p_zero_skew_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (skew == '0 && vs_edge && !hs_edge) |=> (field_start && !field_top));

  p_flag_with_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 1 && !$stable(field_top)) |-> field_start);

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt) |=> ((&cnt) || cnt == 1));
endmodule

bind sync_field_detect sync_field_detect_chk #(.SKEW_W(SKEW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
  .hs_invert(hs_invert), .vs_invert(vs_invert), .vs_fall_sample(vs_fall_sample),
  .skew(skew), .hs_out(hs_out), .vs_out(vs_out), .field_top(field_top),
  .field_start(field_start), .hs_edge(hs_edge), .vs_edge(vs_edge), .cnt(cnt)
);

// File: tb/test_sync_field_detect.sv
module test_sync_field_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_in = 1'b0, vs_in = 1'b0;
  logic hs_invert = 1'b0, vs_invert = 1'b0, vs_fall_sample = 1'b0;
  logic [9:0] skew = '0;
  logic hs_out, vs_out, field_top, field_start;

  int errors = 0, checks = 0;
  int cyc_n = 0, nstb = 0, stb_cyc = 0;
  logic stb_top = 1'b0;
  int hs_tgt = -1, vs_tgt = -1;
  logic hs_seen = 1'b0, vs_seen = 1'b0;

  always #5 clk = ~clk;

  sync_field_detect i_sync_field_detect (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .hs_invert(hs_invert), .vs_invert(vs_invert), .vs_fall_sample(vs_fall_sample),
    .skew(skew), .hs_out(hs_out), .vs_out(vs_out),
    .field_top(field_top), .field_start(field_start)
  );

  always @(negedge clk) begin
    cyc_n++;
    if (field_start) begin
      nstb++;
      stb_cyc = cyc_n;
      stb_top = field_top;
    end
    if (cyc_n == hs_tgt) hs_seen = hs_out;
    if (cyc_n == vs_tgt) vs_seen = vs_out;
    if (cyc_n > 190000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc_n);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (skew=%0d fall=%0d inv=%0d%0d)",
               req, act, exp, skew, vs_fall_sample, hs_invert, vs_invert);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hs_in = hs_invert;
    vs_in = vs_invert;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset field_start", field_start, 0);
    check("R10 reset field_top", field_top, 0);
    rst_n = 1'b1;
    nstb = 0;
    repeat (12) @(posedge clk);
    #1;
    check("R10 no spurious event after reset", nstb, 0);
  endtask

  task automatic trial(input int va, input int d, input int tail);
    int ha, veff, n, c0, dly, top, fall;
    ha   = va + d;
    fall = vs_fall_sample;
    veff = va - fall;
    n    = va + skew + tail;
    @(posedge clk);
    #1;
    c0 = cyc_n;
    check("R1 hs idle low", hs_out, 0);
    check("R2 vs idle low", vs_out, 0);
    nstb   = 0;
    hs_tgt = c0 + ha + 3;
    vs_tgt = c0 + va + 3 - fall;
    hs_seen = 1'b0;
    vs_seen = 1'b0;
    for (int i = 0; i <= n; i++) begin
      if (i > 0) begin
        @(posedge clk);
        #1;
      end
      hs_in = hs_invert ^ (i >= ha && i <= ha + 1);
      vs_in = vs_invert ^ (i >= va && i <= va + 2);
    end
    @(posedge clk);
    #1;
    if (d <= 0 && -d <= skew) begin top = 1; dly = 0; end
    else if (d > 0 && d <= skew) begin top = 1; dly = d; end
    else begin top = 0; dly = skew; end
    // ha - veff is the effective offset; fall shifts vs one cycle earlier
    if (fall) begin
      if (ha - veff <= 0 && veff - ha <= skew) begin top = 1; dly = 0; end
      else if (ha - veff > 0 && ha - veff <= skew) begin top = 1; dly = ha - veff; end
      else begin top = 0; dly = skew; end
    end
    check("R1 hs pulse level", hs_seen, 1);
    check(fall ? "R3 vs falling-sample level" : "R2 vs level", vs_seen, 1);
    check("R9 one strobe per field", nstb, 1);
    if (skew == 0)
      check("R8 zero skew classification", stb_top, top);
    else if (top == 1 && dly > 0)
      check("R6 lookahead top", stb_top, top);
    else if (top == 1)
      check("R5 lookback top", stb_top, top);
    else
      check("R7 bottom field", stb_top, top);
    check(fall ? "R3 strobe cycle falling" : "R4 strobe cycle", stb_cyc - c0, veff + 4 + dly);
    check("R9 flag held after strobe", field_top, top);
  endtask

  initial begin
    int sk[4] = '{0, 1, 3, 6};
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int s = 0; s < 4; s++) begin
        hs_invert      = cfg[0];
        vs_invert      = cfg[1];
        vs_fall_sample = cfg[2];
        skew           = 10'(sk[s]);
        do_reset();
        for (int d = -(sk[s] + 2); d <= sk[s] + 2; d++)
          trial(20, d, 40);
      end
    end
    // R11: largest window, distances at and just past the edge
    skew = 10'd1023;
    for (int cfg = 0; cfg < 2; cfg++) begin
      hs_invert      = 1'b0;
      vs_invert      = 1'b0;
      vs_fall_sample = cfg[0];
      do_reset();
      trial(1030, -1023, 1100);
      trial(1030, -1024, 1100);
      trial(1030, 1023, 1100);
      trial(1030, 1024, 1100);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule